// File: doc/BRIEF.md
# Digital PLL lock detector

This block watches the UP and DOWN pulses that a phase-frequency detector produces and decides whether the loop is in lock. Each comparison cycle starts when either pulse goes high and ends when both are low again. The block measures the phase error of that cycle as the number of measurement-clock cycles during which exactly one of the two pulses is high.

A lock flag rises once a run of consecutive cycles all show an error below an entry threshold. It falls as soon as a single cycle shows an error above a wider exit threshold. A precision input chooses between a coarse entry threshold and a fine one. Errors that fall between the entry threshold and the exit threshold do not break lock, and they do not count toward gaining it. All thresholds and the run length are parameters counted in measurement-clock cycles. With a 1 GHz measurement clock, the defaults correspond to 10 ns and 3 ns for entry and 25 ns for exit.

`up` and `dn` are expected to be synchronous to `clk`.

Top module: `pll_lock_monitor`

## Requirements
- R1: While `rst_n` is low, `locked` is 0 and the run of good cycles is cleared.
- R2: A cycle's error is the count of clock edges that sample exactly one of `up`/`dn` high. The cycle is judged at the first edge that samples both low, and `locked` changes only at that edge. It never changes mid-pulse, and it does not depend on which pulse leads.
- R3: With `fine`=0, lock rises at the judging edge of the GOOD_RUN-th (default 5) consecutive cycle whose error is below WIDE_LIMIT (default 10).
- R4: While unlocked, a cycle with error at or above the current entry threshold clears the run. After GOOD_RUN-1 good cycles `locked` is still 0.
- R5: With `fine`=1, the entry threshold is NARROW_LIMIT (default 3). An error of 3 does not count as good and an error of 2 does.
- R6: While locked, a cycle with error at or below DROP_LIMIT (default 25) keeps `locked` at 1.
- R7: While locked, a cycle with error above DROP_LIMIT clears `locked` at its judging edge. Regaining lock then needs a fresh run of GOOD_RUN good cycles.
- R8: The error count saturates just above DROP_LIMIT. An arbitrarily long single-sided pulse still counts as a large error, and the next cycle is measured from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up | input | 1 | Phase detector UP pulse |
| dn | input | 1 | Phase detector DOWN pulse |
| fine | input | 1 | 1 selects the narrow entry threshold |
| locked | output | 1 | Active-high lock indication |

## Verification
The bench builds the block with its default parameters: WIDE_LIMIT 10, NARROW_LIMIT 3, DROP_LIMIT 25 and GOOD_RUN 5. These values keep every threshold edge reachable with pulses a few tens of cycles long. The directed cases hit both sides of each limit: 9 against 10, 2 against 3, and 25 against 26. A 60-cycle pulse pushes the error counter into saturation, and cycles led by either pulse as well as zero-error cycles are included.

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int unsigned WIDE_LIMIT   = 10,
  parameter int unsigned NARROW_LIMIT = 3,
  parameter int unsigned DROP_LIMIT   = 25,
  parameter int unsigned GOOD_RUN     = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up,
  input  logic dn,
  input  logic fine,
  output logic locked
);
  localparam int unsigned CNT_W = $clog2(DROP_LIMIT + 2);
  localparam int unsigned RUN_W = $clog2(GOOD_RUN + 1);
  localparam logic [CNT_W-1:0] ERR_SAT = CNT_W'(DROP_LIMIT + 1);
  localparam logic [CNT_W-1:0] WIDE_C  = CNT_W'(WIDE_LIMIT);
  localparam logic [CNT_W-1:0] NARROW_C = CNT_W'(NARROW_LIMIT);
  localparam logic [CNT_W-1:0] DROP_C  = CNT_W'(DROP_LIMIT);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(GOOD_RUN - 1);

  logic             busy;
  logic [CNT_W-1:0] err;
  logic [RUN_W-1:0] run;

  wire active  = up | dn;
  wire skew    = up ^ dn;
  wire judge   = busy & ~active;
  wire [CNT_W-1:0] entry = fine ? NARROW_C : WIDE_C;
  wire good    = err < entry;
  wire bad     = err > DROP_C;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      err  <= '0;
    end else if (active) begin
      busy <= 1'b1;
      if (skew && err != ERR_SAT) err <= err + 1'b1;
    end else if (busy) begin
      busy <= 1'b0;
      err  <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      run    <= '0;
    end else if (judge) begin
      if (locked) begin
        if (bad) begin
          locked <= 1'b0;
          run    <= '0;
        end
      end else if (good) begin
        if (run == RUN_LAST) begin
          locked <= 1'b1;
          run    <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end else begin
        run <= '0;
      end
    end
  end
endmodule

// File: rtl/pll_lock_monitor_chk.sv
module pll_lock_monitor_chk #(
  parameter int unsigned GOOD_RUN = 5
) (
  input logic clk,
  input logic rst_n,
  input logic up,
  input logic dn,
  input logic locked,
  input logic [$clog2(GOOD_RUN+1)-1:0] run
);
  assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |=> !locked);

  assert_steady_mid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (up || dn) |=> $stable(locked));

  assert_rise_on_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(!up && !dn));

  assert_run_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run < GOOD_RUN);

  assert_fall_on_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(!up && !dn));
endmodule

bind pll_lock_monitor pll_lock_monitor_chk #(.GOOD_RUN(GOOD_RUN)) u_chk (
  .clk(clk), .rst_n(rst_n), .up(up), .dn(dn), .locked(locked), .run(run)
);

// File: tb/pll_lock_monitor_tb.sv
module pll_lock_monitor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up = 1'b0, dn = 1'b0, fine = 1'b0;
  logic locked;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  pll_lock_monitor u_dut (.clk(clk), .rst_n(rst_n), .up(up), .dn(dn), .fine(fine), .locked(locked));

  always #5 clk = ~clk;

  task automatic check(string req, logic exp);
    checks++;
    if (locked !== exp) begin
      fails++;
      $display("FAIL %s locked=%b expected=%b at %0t", req, locked, exp, $time);
    end
  endtask

  task automatic cmp(int e, bit dn_leads = 1'b0);
    @(negedge clk);
    if (e == 0) begin up = 1'b1; dn = 1'b1; end
    else begin
      if (dn_leads) dn = 1'b1; else up = 1'b1;
      repeat (e) @(negedge clk);
      up = 1'b1; dn = 1'b1;
    end
    repeat (2) @(negedge clk);
    up = 1'b0; dn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1", 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0);
  endtask

  task automatic t_acquire_wide;
    fine = 1'b0;
    for (int i = 0; i < 4; i++) begin
      cmp(9, i[0]);
      check("R4", 1'b0);
    end
    cmp(9, 1'b1);
    check("R3", 1'b1);
  endtask

  task automatic t_hold_drop;
    cmp(25); check("R6", 1'b1);
    cmp(15, 1'b1); check("R6", 1'b1);
    cmp(10); check("R6", 1'b1);
    cmp(26); check("R7", 1'b0);
    for (int i = 0; i < 4; i++) cmp(1);
    check("R7", 1'b0);
    cmp(1); check("R7", 1'b1);
    cmp(40); check("R7", 1'b0);
  endtask

  task automatic t_run_reset;
    for (int i = 0; i < 3; i++) cmp(5);
    cmp(10); check("R4", 1'b0);
    for (int i = 0; i < 4; i++) cmp(5);
    check("R4", 1'b0);
    cmp(5); check("R4", 1'b1);
    cmp(30); check("R7", 1'b0);
  endtask

  task automatic t_fine;
    fine = 1'b1;
    for (int i = 0; i < 5; i++) cmp(3);
    check("R5", 1'b0);
    for (int i = 0; i < 4; i++) cmp(2, i[0]);
    check("R5", 1'b0);
    cmp(2); check("R5", 1'b1);
    cmp(9); check("R6", 1'b1);
    cmp(27); check("R7", 1'b0);
    fine = 1'b0;
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 5; i++) cmp(0);
    check("R2", 1'b1);
    @(negedge clk);
    up = 1'b1;
    repeat (40) @(negedge clk);
    check("R2", 1'b1);
    repeat (20) @(negedge clk);
    up = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", 1'b0);
    for (int i = 0; i < 5; i++) cmp(9);
    check("R8", 1'b1);
  endtask

  initial begin
    t_reset;
    t_acquire_wide;
    t_hold_drop;
    t_run_reset;
    t_fine;
    t_saturate;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired locked=%b expected=done", locked);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule